// File: doc/BRIEF.md
# Relocatable Script Memory Router

This block holds a 1024-word by 32-bit program store for an embedded sequencer, and places it at a programmable 4 KB-aligned window in a 32-bit address space. A host bus reaches the store as a slave target with per-byte write enables and a fixed, short wait-state count. The sequencer has its own private port into the same store.

Each sequencer request is routed by its access kind. Instruction fetches, table-indirect fetches and load/store accesses that fall inside the window are served from the store without any bus activity. Every other sequencer access, and every access outside the window, is raised on the bus-master request outputs exactly as an external access would be. A test control input copies the current base address into a scratch register output so that software can read the base back.

The store responds from reset with no setup write. Dropping the enable input makes the window vanish, so nothing hits it.

Top module: `script_mem_router`

## Requirements
- R1: The store holds 1024 words of 32 bits; a word written through the slave port at window offset 4*k (k in 0..1023) reads back unchanged through the slave port and the sequencer port.
- R2: After reset the store is enabled: slv_ack, seq_ack and scratch are 0, and a slave access to the window is acknowledged without any prior configuration.
- R3: An address hits the window when mem_en is 1 and its bits [31:12] equal base_addr[31:12]; byte offset 0xFFC is the last hit, offset 0x1000 misses, and a slave access that misses is never acknowledged.
- R4: A sequencer request with seq_kind 0 (instruction fetch) or 1 (table-indirect fetch) that hits the window is served internally: mst_req stays 0 and seq_ack is 1 in the cycle after the request, with seq_rdata holding the addressed word.
- R5: A sequencer request with seq_kind 2 (load/store) that hits the window is served internally; with seq_we at 1 it writes the whole 32-bit word seq_wdata.
- R6: A sequencer request with seq_kind 3 (other), or any sequencer request that misses the window, drives mst_req to 1 in the same cycle with mst_addr, mst_we and mst_wdata equal to the request, and produces no seq_ack.
- R7: On a slave write, byte lane i (bits 8i+7..8i) of the addressed word is updated only when slv_be[i] is 1.
- R8: A slave access that hits the window is sampled at four rising edges before completion: three wait cycles then the access; slv_ack is 1 for exactly the one cycle after the fourth edge, with slv_rdata valid in that cycle.
- R9: When the sequencer is served internally in a cycle where a slave access is pending, the sequencer wins and the slave acknowledge is delayed by one cycle for each such cycle.
- R10: With mem_en at 0, no slave access is acknowledged and every sequencer request, of any kind, is raised on mst_req.
- R11: At each rising edge where mirror_en is 1, scratch takes base_addr; otherwise scratch holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_en | input | 1 | Window enable |
| base_addr | input | 32 | Window base address |
| mirror_en | input | 1 | Copy base into scratch |
| scratch | output | 32 | Mirrored base address |
| slv_req | input | 1 | Slave request, held until ack |
| slv_we | input | 1 | Slave write |
| slv_addr | input | 30 | Slave word address (byte address bits 31..2) |
| slv_be | input | 4 | Slave byte enables |
| slv_wdata | input | 32 | Slave write data |
| slv_ack | output | 1 | Slave completion pulse |
| slv_rdata | output | 32 | Slave read data |
| seq_req | input | 1 | Sequencer request, one access per cycle |
| seq_kind | input | 2 | Access kind: 0 fetch, 1 table, 2 load/store, 3 other |
| seq_we | input | 1 | Sequencer write |
| seq_addr | input | 32 | Sequencer byte address |
| seq_wdata | input | 32 | Sequencer write data |
| seq_ack | output | 1 | Internal service done |
| seq_rdata | output | 32 | Internal read data |
| mst_req | output | 1 | Request routed to bus master |
| mst_we | output | 1 | Routed write |
| mst_addr | output | 32 | Routed address |
| mst_wdata | output | 32 | Routed write data |

## Verification
The slave port and the sequencer port share one single-ported store, so an internal sequencer access and a pending slave access can fall in the same cycle. The bench raises a slave read and an internal sequencer fetch at the same clock edge, holds the fetch for two cycles, and counts the edges until slv_ack: the fetches must be acknowledged with the right data in their own cycles, and the slave acknowledge must arrive exactly two edges later than in an undisturbed access with correct read data.

// File: rtl/smr_pkg.sv
package smr_pkg;
    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_TABLE = 2'd1,
        KIND_LDST  = 2'd2,
        KIND_OTHER = 2'd3
    } seq_kind_e;
endpackage

// File: rtl/smr_window.sv
module smr_window #(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 12
) (
    input  logic                     en,
    input  logic [ADDR_W-1:OFFS_W]   base_page,
    input  logic [ADDR_W-1:OFFS_W]   addr_page,
    output logic                     hit
);
    always_comb begin
        hit = en && (addr_page == base_page);
    end
endmodule

// File: rtl/smr_bank.sv
module smr_bank #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [DEPTH];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                store[idx][8*g +: 8] <= wdata[8*g +: 8];
            end
        end
    end

    always_comb begin
        rdata = store[idx];
    end
endmodule

// File: rtl/script_mem_router.sv
module script_mem_router
    import smr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 1024,
    parameter int SLV_WAIT = 3,
    localparam int LANES   = DATA_W / 8,
    localparam int LANE_W  = $clog2(LANES),
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int OFFS_W  = IDX_W + LANE_W,
    localparam int WAIT_W  = $clog2(SLV_WAIT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mem_en,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic                     mirror_en,
    output logic [ADDR_W-1:0]        scratch,
    input  logic                     slv_req,
    input  logic                     slv_we,
    input  logic [ADDR_W-1:LANE_W]   slv_addr,
    input  logic [LANES-1:0]         slv_be,
    input  logic [DATA_W-1:0]        slv_wdata,
    output logic                     slv_ack,
    output logic [DATA_W-1:0]        slv_rdata,
    input  logic                     seq_req,
    input  logic [1:0]               seq_kind,
    input  logic                     seq_we,
    input  logic [ADDR_W-1:0]        seq_addr,
    input  logic [DATA_W-1:0]        seq_wdata,
    output logic                     seq_ack,
    output logic [DATA_W-1:0]        seq_rdata,
    output logic                     mst_req,
    output logic                     mst_we,
    output logic [ADDR_W-1:0]        mst_addr,
    output logic [DATA_W-1:0]        mst_wdata
);
    localparam logic [WAIT_W-1:0] WAIT_MAX = WAIT_W'(SLV_WAIT);

    typedef struct packed {
        logic [WAIT_W-1:0] wait_cnt;
        logic              slv_ack;
        logic [DATA_W-1:0] slv_rdata;
        logic              seq_ack;
        logic [DATA_W-1:0] seq_rdata;
        logic [ADDR_W-1:0] scratch;
    } state_t;

    state_t st_d, st_q;

    logic              slv_hit, seq_hit;
    logic              seq_int, slv_pend, slv_go;
    logic              bank_we;
    logic [IDX_W-1:0]  bank_idx;
    logic [LANES-1:0]  bank_be;
    logic [DATA_W-1:0] bank_wdata, bank_rdata;
    seq_kind_e         kind;

    smr_window #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_slv_win (
        .en        (mem_en),
        .base_page (base_addr[ADDR_W-1:OFFS_W]),
        .addr_page (slv_addr[ADDR_W-1:OFFS_W]),
        .hit       (slv_hit)
    );

    smr_window #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_seq_win (
        .en        (mem_en),
        .base_page (base_addr[ADDR_W-1:OFFS_W]),
        .addr_page (seq_addr[ADDR_W-1:OFFS_W]),
        .hit       (seq_hit)
    );

    smr_bank #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .we    (bank_we),
        .idx   (bank_idx),
        .be    (bank_be),
        .wdata (bank_wdata),
        .rdata (bank_rdata)
    );

    // Routing and port arbitration: the sequencer always wins the bank.
    always_comb begin
        kind     = seq_kind_e'(seq_kind);
        seq_int  = seq_req && seq_hit && (kind != KIND_OTHER);
        slv_pend = slv_req && slv_hit && !st_q.slv_ack;
        slv_go   = slv_pend && !seq_int && (st_q.wait_cnt == WAIT_MAX);

        mst_req   = seq_req && !seq_int;
        mst_we    = seq_we;
        mst_addr  = seq_addr;
        mst_wdata = seq_wdata;

        if (seq_int) begin
            bank_idx   = seq_addr[OFFS_W-1:LANE_W];
            bank_we    = seq_we && (kind == KIND_LDST);
            bank_be    = '1;
            bank_wdata = seq_wdata;
        end else begin
            bank_idx   = slv_addr[OFFS_W-1:LANE_W];
            bank_we    = slv_go && slv_we;
            bank_be    = slv_be;
            bank_wdata = slv_wdata;
        end
    end

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        if (!slv_pend) begin
            st_d.wait_cnt = '0;
        end else if (!seq_int && st_q.wait_cnt != WAIT_MAX) begin
            st_d.wait_cnt = st_q.wait_cnt + 1'b1;
        end
        st_d.slv_ack = slv_go;
        if (slv_go) begin
            st_d.slv_rdata = bank_rdata;
        end
        st_d.seq_ack = seq_int;
        if (seq_int) begin
            st_d.seq_rdata = bank_rdata;
        end
        if (mirror_en) begin
            st_d.scratch = base_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        slv_ack   = st_q.slv_ack;
        slv_rdata = st_q.slv_rdata;
        seq_ack   = st_q.seq_ack;
        seq_rdata = st_q.seq_rdata;
        scratch   = st_q.scratch;
    end

    // R8
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack |=> !slv_ack);

    // R8
    ack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack |-> ($past(rst_n) && $past(slv_req) && $past(st_q.wait_cnt) == WAIT_MAX));

    // R10
    ack_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slv_ack |-> $past(mem_en));

    // R4
    seq_ack_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_ack |-> ($past(rst_n) && $past(seq_req) && $past(seq_kind) != 2'd3));

    // R9
    seq_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_int && slv_req && !slv_ack) |=> !slv_ack);

    // R11
    mirror_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mirror_en)) |-> scratch == $past(base_addr));

    // R11
    mirror_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mirror_en)) |-> $stable(scratch));
endmodule

// File: tb/sim_script_mem_router.sv
module sim_script_mem_router;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_en = 1'b1;
    logic [31:0] base_addr = 32'h0001_0000;
    logic        mirror_en = 1'b0;
    logic [31:0] scratch;
    logic        slv_req = 1'b0, slv_we = 1'b0;
    logic [31:0] slv_baddr = '0;
    logic [3:0]  slv_be = '0;
    logic [31:0] slv_wdata = '0;
    logic        slv_ack;
    logic [31:0] slv_rdata;
    logic        seq_req = 1'b0, seq_we = 1'b0;
    logic [1:0]  seq_kind = '0;
    logic [31:0] seq_addr = '0, seq_wdata = '0;
    logic        seq_ack;
    logic [31:0] seq_rdata;
    logic        mst_req, mst_we;
    logic [31:0] mst_addr, mst_wdata;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    script_mem_router u0 (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .base_addr(base_addr),
        .mirror_en(mirror_en), .scratch(scratch),
        .slv_req(slv_req), .slv_we(slv_we), .slv_addr(slv_baddr[31:2]),
        .slv_be(slv_be), .slv_wdata(slv_wdata), .slv_ack(slv_ack), .slv_rdata(slv_rdata),
        .seq_req(seq_req), .seq_kind(seq_kind), .seq_we(seq_we), .seq_addr(seq_addr),
        .seq_wdata(seq_wdata), .seq_ack(seq_ack), .seq_rdata(seq_rdata),
        .mst_req(mst_req), .mst_we(mst_we), .mst_addr(mst_addr), .mst_wdata(mst_wdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Slave access; returns number of edges until ack (99 if none in limit).
    task automatic slave(input logic we, input logic [31:0] a, input logic [3:0] be,
                         input logic [31:0] d, input int limit,
                         output logic [31:0] rd, output int edges);
        @(negedge clk);
        slv_req = 1'b1; slv_we = we; slv_baddr = a; slv_be = be; slv_wdata = d;
        edges = 99; rd = '0;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk); #1;
            if (slv_ack) begin edges = i; rd = slv_rdata; break; end
        end
        @(negedge clk);
        slv_req = 1'b0; slv_we = 1'b0;
    endtask

    // One-cycle sequencer request; reports same-cycle mst_req and next-cycle ack/data.
    task automatic seq(input logic [1:0] k, input logic we, input logic [31:0] a,
                       input logic [31:0] d, output logic mreq, output logic ack,
                       output logic [31:0] rd);
        @(negedge clk);
        seq_req = 1'b1; seq_kind = k; seq_we = we; seq_addr = a; seq_wdata = d;
        #1 mreq = mst_req;
        if (mst_req) begin
            check("R6 mst_addr", mst_addr, a);
            check("R6 mst_we", {31'b0, mst_we}, {31'b0, we});
            check("R6 mst_wdata", mst_wdata, d);
        end
        @(posedge clk); #1;
        ack = seq_ack; rd = seq_rdata;
        seq_req = 1'b0; seq_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] rd; int e;
        check("R2 slv_ack reset", {31'b0, slv_ack}, 32'd0);
        check("R2 seq_ack reset", {31'b0, seq_ack}, 32'd0);
        check("R2 scratch reset", scratch, 32'd0);
        slave(1'b1, 32'h0001_0000, 4'hF, 32'hCAFE_0001, 20, rd, e);
        check("R2 ack without setup", e, 4);
    endtask

    task automatic t_rw_timing;
        logic [31:0] rd; int e;
        slave(1'b1, 32'h0001_0040, 4'hF, 32'h1234_5678, 20, rd, e);
        check("R8 write wait edges", e, 4);
        slave(1'b0, 32'h0001_0040, 4'h0, 32'h0, 20, rd, e);
        check("R8 read wait edges", e, 4);
        check("R1 read back", rd, 32'h1234_5678);
        @(posedge clk); #1;
        check("R8 ack single cycle", {31'b0, slv_ack}, 32'd0);
    endtask

    task automatic t_bytes;
        logic [31:0] rd; int e;
        slave(1'b1, 32'h0001_0080, 4'hF, 32'hAABB_CCDD, 20, rd, e);
        slave(1'b1, 32'h0001_0080, 4'b0101, 32'h1122_3344, 20, rd, e);
        slave(1'b0, 32'h0001_0080, 4'h0, 32'h0, 20, rd, e);
        check("R7 lanes 0 and 2", rd, 32'hAA22_CC44);
        slave(1'b1, 32'h0001_0080, 4'b1000, 32'h5500_0000, 20, rd, e);
        slave(1'b0, 32'h0001_0080, 4'h0, 32'h0, 20, rd, e);
        check("R7 lane 3", rd, 32'h5522_CC44);
    endtask

    task automatic t_seq_routes;
        logic m, a; logic [31:0] rd, srd; int e;
        slave(1'b1, 32'h0001_0100, 4'hF, 32'hF00D_0100, 20, srd, e);
        seq(2'd0, 1'b0, 32'h0001_0100, 32'h0, m, a, rd);
        check("R4 fetch no mst_req", {31'b0, m}, 32'd0);
        check("R4 fetch ack", {31'b0, a}, 32'd1);
        check("R4 fetch data", rd, 32'hF00D_0100);
        seq(2'd1, 1'b0, 32'h0001_0100, 32'h0, m, a, rd);
        check("R4 table no mst_req", {31'b0, m}, 32'd0);
        check("R4 table data", rd, 32'hF00D_0100);
        seq(2'd2, 1'b1, 32'h0001_0104, 32'h7777_8888, m, a, rd);
        check("R5 ldst no mst_req", {31'b0, m}, 32'd0);
        check("R5 ldst ack", {31'b0, a}, 32'd1);
        slave(1'b0, 32'h0001_0104, 4'h0, 32'h0, 20, srd, e);
        check("R5 ldst write seen by slave", srd, 32'h7777_8888);
        seq(2'd3, 1'b1, 32'h0001_0104, 32'h0BAD_0BAD, m, a, rd);
        check("R6 other kind mst_req", {31'b0, m}, 32'd1);
        check("R6 other kind no ack", {31'b0, a}, 32'd0);
        slave(1'b0, 32'h0001_0104, 4'h0, 32'h0, 20, srd, e);
        check("R6 other write not stored", srd, 32'h7777_8888);
        seq(2'd0, 1'b0, 32'h0002_0100, 32'h0, m, a, rd);
        check("R6 miss mst_req", {31'b0, m}, 32'd1);
        check("R6 miss no ack", {31'b0, a}, 32'd0);
    endtask

    task automatic t_window;
        logic m, a; logic [31:0] rd; int e;
        base_addr = 32'h8000_3000;
        slave(1'b1, 32'h8000_3FFC, 4'hF, 32'hEEEE_0FFC, 20, rd, e);
        check("R3 last word hit", e, 4);
        slave(1'b0, 32'h8000_4000, 4'h0, 32'h0, 10, rd, e);
        check("R3 past window miss", e, 99);
        slave(1'b0, 32'h0001_0040, 4'h0, 32'h0, 10, rd, e);
        check("R3 old base miss", e, 99);
        seq(2'd0, 1'b0, 32'h8000_3FFC, 32'h0, m, a, rd);
        check("R1 word 1023 via sequencer", rd, 32'hEEEE_0FFC);
        slave(1'b0, 32'h8000_3040, 4'h0, 32'h0, 20, rd, e);
        check("R1 relocated word kept", rd, 32'h1234_5678);
    endtask

    task automatic t_conflict;
        int e = 99;
        @(negedge clk);
        slv_req = 1'b1; slv_we = 1'b0; slv_baddr = 32'h8000_3FFC; slv_be = 4'h0;
        seq_req = 1'b1; seq_kind = 2'd0; seq_we = 1'b0; seq_addr = 32'h8000_3040;
        for (int i = 1; i <= 20; i++) begin
            @(posedge clk); #1;
            if (i <= 2) begin
                check("R9 seq served during conflict", {31'b0, seq_ack}, 32'd1);
                check("R9 seq data during conflict", seq_rdata, 32'h1234_5678);
            end
            if (i == 2) seq_req = 1'b0;
            if (slv_ack) begin
                e = i;
                check("R9 slave data after conflict", slv_rdata, 32'hEEEE_0FFC);
                break;
            end
        end
        check("R9 slave delayed two edges", e, 6);
        @(negedge clk);
        slv_req = 1'b0;
    endtask

    task automatic t_disabled;
        logic m, a; logic [31:0] rd; int e;
        mem_en = 1'b0;
        slave(1'b0, 32'h8000_3040, 4'h0, 32'h0, 10, rd, e);
        check("R10 no slave ack when disabled", e, 99);
        seq(2'd0, 1'b0, 32'h8000_3040, 32'h0, m, a, rd);
        check("R10 fetch goes external", {31'b0, m}, 32'd1);
        check("R10 no seq ack", {31'b0, a}, 32'd0);
        mem_en = 1'b1;
        slave(1'b0, 32'h8000_3040, 4'h0, 32'h0, 20, rd, e);
        check("R10 re-enabled ack", e, 4);
    endtask

    task automatic t_mirror;
        @(negedge clk);
        mirror_en = 1'b1;
        @(negedge clk);
        check("R11 scratch copies base", scratch, 32'h8000_3000);
        mirror_en = 1'b0;
        base_addr = 32'h4000_5000;
        @(negedge clk); @(negedge clk);
        check("R11 scratch holds", scratch, 32'h8000_3000);
        mirror_en = 1'b1;
        @(negedge clk);
        mirror_en = 1'b0;
        check("R11 scratch follows new base", scratch, 32'h4000_5000);
    endtask

    initial begin
        #(CLK_P * 50000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_rw_timing();
        t_bytes();
        t_seq_routes();
        t_window();
        t_conflict();
        t_disabled();
        t_mirror();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule